// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

This block sits in the decode stage of an out-of-order core and breaks one block-transfer instruction into simple micro-ops. Such an instruction names a base register, a 16-bit register mask, a direction (load or store) and an optional base update. Rename only handles micro-ops with one destination, so the sequencer turns the instruction into a stream of single-register loads or stores, one for each set mask bit. These use word offsets 0, 4, 8, … from the base. When a base update is requested, the stream ends with one add micro-op that advances the base past the transferred block.

The mask is scanned from bit 0 upward. This pairs the lowest-numbered register with the lowest address, as the transfer order demands. At most one micro-op is offered per cycle on a valid/ready output, and rename can stall it for any number of cycles. A new instruction is accepted only when the previous one has fully drained. A one-cycle `done` pulse marks the end of each instruction, including an instruction that produces nothing.

Top module: `lsm_uop_seq`

## Requirements
- R1: After a synchronous reset, `out_valid` and `done` are 0 and `in_ready` is 1.
- R2: One transfer micro-op is produced for each set bit of the accepted mask, in ascending register-number order, with `out_reg` equal to that register number.
- R3: The k-th transfer (counting from 0) carries `out_imm` = 4*k, which is always a multiple of 4, and `out_base` equal to the accepted base register.
- R4: Transfer micro-ops have `out_kind` 0 when the load flag was 1, and 1 when it was 0. No micro-op ever shows `out_kind` 3.
- R5: When the writeback flag was set, the last micro-op has `out_kind` 2, with `out_reg` and `out_base` both equal to the base register and `out_imm` = 4 × (number of set mask bits). Without writeback, no add micro-op is produced.
- R6: `out_last` is 1 on the final micro-op of an instruction and 0 on every other one.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value into the next cycle.
- R8: `in_ready` is 0 from the cycle after acceptance until the final micro-op has been handed off. Any `in_valid` presented during that time is ignored and does not alter the stream.
- R9: An empty mask produces no transfers. It gives only the add (immediate 0) if writeback is set, and otherwise nothing, with `done` pulsing in the cycle after acceptance.
- R10: `done` is 1 for exactly the cycle after the final micro-op handshake, is 0 while the instruction is still draining, and is never 1 while `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle and able to accept |
| in_base | input | 4 | Base register number |
| in_list | input | 16 | Register mask, bit i selects register i |
| in_is_load | input | 1 | 1 = load direction, 0 = store direction |
| in_wb | input | 1 | 1 = append base-update add |
| out_valid | output | 1 | Micro-op offered |
| out_ready | input | 1 | Rename takes the micro-op |
| out_kind | output | 2 | 0 load, 1 store, 2 add |
| out_reg | output | 4 | Data register (transfer) or destination base (add) |
| out_base | output | 4 | Base register used as source |
| out_imm | output | 7 | Byte offset (transfer) or base increment (add) |
| out_last | output | 1 | Final micro-op of the instruction |
| done | output | 1 | One-cycle pulse when an instruction completes |

## Verification
The hardest situation to reach from the ports is a back-pressure stall that lands exactly on a boundary. Examples are holding the final transfer just before the add, or holding the add itself, while a second instruction waits at the input. The bench drives `out_ready` from a random source with several duty cycles and keeps `in_valid` asserted with junk fields for the whole drain. Every stall position and the input-block window are therefore visited across random masks. Directed cases cover empty, single-bit top and bottom, and full masks, with and without writeback.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    UOP_LOAD  = 2'd0,
    UOP_STORE = 2'd1,
    UOP_ADD   = 2'd2
  } uop_kind_e;
endpackage

// File: rtl/lsm_lowbit.sv
// Finds the lowest set bit of a mask and the mask with that bit removed.
module lsm_lowbit #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  rest,
  output logic          any,
  output logic          single
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = i[IW-1:0];
    end
  end

  assign rest   = vec & (vec - N'(1));
  assign any    = |vec;
  assign single = any && (rest == '0);
endmodule

// File: rtl/lsm_popcnt.sv
// Counts set bits of the register mask.
module lsm_popcnt #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(vec[i]);
    end
  end
endmodule

// File: rtl/lsm_uop_seq.sv
module lsm_uop_seq #(
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4,
  parameter int REGW       = $clog2(NREG),
  parameter int IMMW       = $clog2(NREG + 1) + $clog2(WORD_BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [REGW-1:0] in_base,
  input  logic [NREG-1:0] in_list,
  input  logic            in_is_load,
  input  logic            in_wb,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [1:0]      out_kind,
  output logic [REGW-1:0] out_reg,
  output logic [REGW-1:0] out_base,
  output logic [IMMW-1:0] out_imm,
  output logic            out_last,
  output logic            done
);
  import lsm_pkg::*;

  localparam int CW   = $clog2(NREG + 1);
  localparam int OFFW = $clog2(WORD_BYTES);

  // pending work
  logic [NREG-1:0] rem_q;
  logic            wb_pend_q;
  logic [REGW-1:0] base_q;
  logic            load_q;
  logic [IMMW-1:0] off_q;
  logic [IMMW-1:0] wbimm_q;

  // scan and count
  logic [REGW-1:0] pick_idx;
  logic [NREG-1:0] pick_rest;
  logic            pick_any;
  logic            pick_single;
  logic [CW-1:0]   in_cnt;

  lsm_lowbit #(.N(NREG), .IW(REGW)) u_lowbit (
    .vec   (rem_q),
    .idx   (pick_idx),
    .rest  (pick_rest),
    .any   (pick_any),
    .single(pick_single)
  );

  lsm_popcnt #(.N(NREG), .CW(CW)) u_popcnt (
    .vec(in_list),
    .cnt(in_cnt)
  );

  logic have_next, slot_free, accept, advance;

  assign have_next = pick_any || wb_pend_q;
  assign slot_free = !out_valid || out_ready;
  assign in_ready  = !have_next && !out_valid;
  assign accept    = in_valid && in_ready;
  assign advance   = have_next && slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q     <= '0;
      wb_pend_q <= 1'b0;
      base_q    <= '0;
      load_q    <= 1'b0;
      off_q     <= '0;
      wbimm_q   <= '0;
      out_valid <= 1'b0;
      out_kind  <= UOP_LOAD;
      out_reg   <= '0;
      out_base  <= '0;
      out_imm   <= '0;
      out_last  <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        if (out_last) done <= 1'b1;
      end
      if (accept) begin
        rem_q     <= in_list;
        wb_pend_q <= in_wb;
        base_q    <= in_base;
        load_q    <= in_is_load;
        off_q     <= '0;
        wbimm_q   <= IMMW'(in_cnt) << OFFW;
        if (in_list == '0 && !in_wb) done <= 1'b1;
      end else if (advance) begin
        out_valid <= 1'b1;
        out_base  <= base_q;
        if (pick_any) begin
          out_kind <= load_q ? UOP_LOAD : UOP_STORE;
          out_reg  <= pick_idx;
          out_imm  <= off_q;
          out_last <= pick_single && !wb_pend_q;
          rem_q    <= pick_rest;
          off_q    <= off_q + IMMW'(WORD_BYTES);
        end else begin
          out_kind  <= UOP_ADD;
          out_reg   <= base_q;
          out_imm   <= wbimm_q;
          out_last  <= 1'b1;
          wb_pend_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lsm_uop_seq_chk.sv
module lsm_uop_seq_chk #(
  parameter int REGW = 4,
  parameter int IMMW = 7,
  parameter int OFFW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [1:0]      out_kind,
  input logic [REGW-1:0] out_reg,
  input logic [REGW-1:0] out_base,
  input logic [IMMW-1:0] out_imm,
  input logic            out_last,
  input logic            done
);
  // R7
  hold_offer_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_reg)
      && $stable(out_base) && $stable(out_imm) && $stable(out_last));

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R5
  add_final_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kind == 2'd2 |-> out_last && out_reg == out_base);

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kind != 2'd2 |-> out_imm[OFFW-1:0] == '0);

  // R4
  kind_legal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_kind != 2'd3);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);
endmodule

bind lsm_uop_seq lsm_uop_seq_chk #(.REGW(REGW), .IMMW(IMMW), .OFFW($clog2(WORD_BYTES))) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_kind(out_kind), .out_reg(out_reg),
  .out_base(out_base), .out_imm(out_imm), .out_last(out_last), .done(done)
);

// File: tb/test_lsm_uop_seq.sv
module test_lsm_uop_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_is_load, in_wb;
  logic [3:0]  in_base;
  logic [15:0] in_list;
  logic        out_valid, out_ready, out_last, done;
  logic [1:0]  out_kind;
  logic [3:0]  out_reg, out_base;
  logic [6:0]  out_imm;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  lsm_uop_seq i_lsm_uop_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_list(in_list), .in_is_load(in_is_load), .in_wb(in_wb),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_reg(out_reg), .out_base(out_base), .out_imm(out_imm),
    .out_last(out_last), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int popc(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // stall_pct: probability (0..100) that out_ready is low in a cycle
  task automatic run_instr(input logic [3:0] base, input logic [15:0] list,
                           input logic ld, input logic wb, input int stall_pct);
    int ek[17], er[17], ei[17], el[17];
    int n = 0, k = 0, idx = 0, guard = 0;
    bit prev_stall = 0;
    for (int r = 0; r < 16; r++) begin
      if (list[r]) begin
        ek[n] = ld ? 0 : 1; er[n] = r; ei[n] = 4 * k; el[n] = 0;
        n++; k++;
      end
    end
    if (wb) begin
      ek[n] = 2; er[n] = base; ei[n] = 4 * popc(list); el[n] = 0; n++;
    end
    if (n > 0) el[n-1] = 1;

    @(negedge clk);
    chk("R8 in_ready idle", int'(in_ready), 1);
    in_valid = 1'b1; in_base = base; in_list = list; in_is_load = ld; in_wb = wb;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (n == 0) begin
      in_valid = 1'b0;
      chk("R9 done after empty", int'(done), 1);
      chk("R9 no micro-op", int'(out_valid), 0);
      return;
    end
    // junk request held during drain (R8)
    in_base = 4'($urandom); in_list = 16'($urandom);
    in_is_load = 1'($urandom); in_wb = 1'($urandom);
    while (idx < n && guard < 2000) begin
      guard++;
      out_ready = (($urandom % 100) >= stall_pct);
      chk("R10 done low mid-stream", int'(done), 0);
      if (out_valid) begin
        chk("R8 in_ready busy", int'(in_ready), 0);
        chk(prev_stall ? "R7 held kind" : (ek[idx] == 2 ? "R5 add kind" : "R4 kind"),
            int'(out_kind), ek[idx]);
        chk(ek[idx] == 2 ? "R5 add reg" : "R2 reg order", int'(out_reg), er[idx]);
        chk("R3 base field", int'(out_base), int'(base));
        chk(ek[idx] == 2 ? "R5 add imm" : "R3 offset", int'(out_imm), ei[idx]);
        chk("R6 last flag", int'(out_last), el[idx]);
        prev_stall = !out_ready;
        if (out_ready) begin
          idx++;
          if (idx == n) in_valid = 1'b0;
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk("R2 micro-op count", idx, n);
    chk("R10 done after last", int'(done), 1);
    chk("R6 no extra micro-op", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_1144));
    rst = 1'b1; in_valid = 1'b0; in_base = '0; in_list = '0;
    in_is_load = 1'b0; in_wb = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 in_ready", int'(in_ready), 1);

    // directed corners
    run_instr(4'd5, 16'h0000, 1'b1, 1'b0, 0);   // R9 empty, no writeback
    run_instr(4'd5, 16'h0000, 1'b0, 1'b1, 30);  // R9 empty, add only
    run_instr(4'd13, 16'hFFFF, 1'b1, 1'b1, 0);  // R5 full mask, imm 64
    run_instr(4'd2, 16'h8000, 1'b0, 1'b1, 50);  // R2 top bit only
    run_instr(4'd0, 16'h0001, 1'b1, 1'b0, 0);   // R6 single transfer is last
    run_instr(4'd7, 16'h000F, 1'b1, 1'b1, 80);  // R7 heavy stall
    run_instr(4'd9, 16'hA5A5, 1'b0, 1'b0, 0);   // R4 store, no add

    // random
    for (int t = 0; t < 60; t++) begin
      run_instr(4'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 4) * 25);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule